// File: doc/BRIEF.md
# Audio Serial Port Control and Status Register Unit

This block is the software-visible register front end of a stereo audio serial port. A host writes 32-bit words through a simple word-addressed register bus. Paired enable and disable strobes in a write-only control word switch the receiver, the transmitter and the bit clock on and off. A mode word is stored and handed unchanged to the serial datapath. The receive and transmit holding words move samples between the bus and that datapath. The serial shifting and clock generation sit outside this unit.

The receiver and transmitter report hardware events through pulse inputs:
- A delivered word from the receiver loads the receive holding word. If that word is still unread, the event is counted as an overrun.
- A word taken by the transmitter empties the transmit holding word. If nothing was waiting, the event is counted as an underrun.

Overrun and underrun leave sticky summary flags and sticky per-channel flags for up to eight channels. Software clears these flags with a write-one-to-clear port and can force them with a write-one-to-set port. An interrupt mask is built through separate set and clear ports. A level interrupt is raised while any masked-in status bit is set.

Top module: `aud_ser_csr`

## Requirements
- R1: Registers sit at word index (byte offset / 4): 0 control, 1 mode, 2 status, 3 status clear, 4 status set, 5 irq set, 6 irq clear, 7 irq mask, 8 receive holding, 9 transmit holding, 10 version. Control, status clear, status set, irq set, irq clear and transmit holding read as zero. Version reads the VERSION parameter.
- R2: A control write acts on three enables. Bit 0 sets and bit 1 clears the receiver enable, bit 2 sets and bit 3 clears the clock enable, and bit 4 sets and bit 5 clears the transmitter enable. When both bits of a pair are one, the enable is cleared. A pair with both bits zero keeps its state.
- R3: The mode word is read/write on all 32 bits and drives mode_o.
- R4: A receive event while the receiver is enabled loads rx_data_i into the receive holding word and sets status bit 1. Reading index 8 returns that word and clears bit 1. Receive events while the receiver is disabled change nothing.
- R5: A receive event that arrives while status bit 1 is set, with no read of index 8 in the same cycle, sets the sticky overrun flags: status bit 2 and status bit 8+rx_ch_i.
- R6: Writing index 9 loads tx_data_o and marks the holding word full. A transmit event while the transmitter is enabled marks it empty. Status bit 5 equals the transmitter enable AND holding-empty. The holding word is empty after reset.
- R7: A transmit event while the transmitter is enabled and the holding word is empty sets the sticky underrun flags: status bit 6 and status bit 20+tx_ch_i.
- R8: Ones written to the status clear port clear the matching sticky bits (2, 6, 15:8, 27:20). A hardware event that sets a bit in the same cycle keeps that bit set.
- R9: Ones written to the status set port set the matching sticky bits (2, 6, 15:8, 27:20). Other status bits are unaffected.
- R10: Ones written to the irq set port set mask bits, and ones written to the irq clear port clear them. Only bits 1, 2, 5 and 6 can be held. The mask reads at index 7.
- R11: irq_o is high exactly when the status word ANDed with the mask is nonzero. It follows the status as a level.
- R12: A control write with bit 7 set returns the enables, mode, mask, holding words and all sticky flags to zero and the transmit holding word to empty. This overrides every other bit of that write.
- R13: Status bit 0 mirrors the receiver enable and status bit 4 mirrors the transmitter enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| rx_word_i | input | 1 | Receiver delivered a word |
| rx_ch_i | input | CH_W | Channel of the delivered word |
| rx_data_i | input | 32 | Delivered word |
| tx_take_i | input | 1 | Transmitter took a word |
| tx_ch_i | input | CH_W | Channel of the taken word |
| tx_data_o | output | 32 | Transmit holding word |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| clk_en_o | output | 1 | Bit clock enable |
| mode_o | output | 32 | Mode word |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every combination of the six strobe bits from both an all-on and an all-off start. A design that let an enable win over its disable, or disturbed an idle pair, would leave an enable in the wrong state.

Overrun and underrun are forced on each of the eight channels in turn and then cleared. A design with a wrong bit offset, or one that skipped the per-channel flags in a clear, would leave stray status bits. A clear written in the same cycle as a new underrun must not erase it; a design that let the clear win would lose that error.

Every one of the 16 legal mask patterns is written with illegal bits alongside. A design that held illegal mask bits, or derived the interrupt from the wrong status bit, would read back the wrong mask or raise the wrong interrupt. Software reset is checked to restore an empty transmit holding word, not only zeros.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [3:0] {
    R_CTRL = 4'd0,
    R_MODE = 4'd1,
    R_STAT = 4'd2,
    R_SCLR = 4'd3,
    R_SSET = 4'd4,
    R_IEN  = 4'd5,
    R_IDIS = 4'd6,
    R_IMSK = 4'd7,
    R_RXH  = 4'd8,
    R_TXH  = 4'd9,
    R_VER  = 4'd10
  } reg_idx_e;

  // status bit positions
  localparam int unsigned ST_RX_EN  = 0;
  localparam int unsigned ST_RX_RDY = 1;
  localparam int unsigned ST_RX_OVR = 2;
  localparam int unsigned ST_TX_EN  = 4;
  localparam int unsigned ST_TX_RDY = 5;
  localparam int unsigned ST_TX_UND = 6;
  localparam int unsigned ST_RX_CH  = 8;
  localparam int unsigned ST_TX_CH  = 20;

  localparam int unsigned CT_SWRST  = 7;
  localparam int unsigned N_EN      = 3;  // 0 rx, 1 clk, 2 tx

  localparam logic [DW-1:0] IRQ_LEGAL = 32'h0000_0066;
endpackage

// File: rtl/aud_csr_enables.sv
module aud_csr_enables #(
  parameter int unsigned N_PAIR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              wr_i,
  input  logic [N_PAIR-1:0] on_i,
  input  logic [N_PAIR-1:0] off_i,
  output logic [N_PAIR-1:0] en_o
);
  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 en_q <= 1'b0;
      else if (srst_i)             en_q <= 1'b0;
      else if (wr_i && off_i[g])   en_q <= 1'b0;  // disable wins
      else if (wr_i && on_i[g])    en_q <= 1'b1;
    end
    assign en_o[g] = en_q;

    a_r2_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && off_i[g]) |=> !en_o[g]);
    a_r2_on_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && on_i[g] && !off_i[g] && !srst_i) |=> en_o[g]);
    a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && !srst_i) |=> $stable(en_o[g]));
  end
endmodule

// File: rtl/aud_csr_sticky.sv
module aud_csr_sticky #(
  parameter int unsigned CH_N = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            srst_i,
  input  logic            evt_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            clr_sum_i,
  input  logic [CH_N-1:0] clr_ch_i,
  input  logic            set_sum_i,
  input  logic [CH_N-1:0] set_ch_i,
  output logic            sum_o,
  output logic [CH_N-1:0] ch_o
);
  logic sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sum_q <= 1'b0;
    else if (srst_i)              sum_q <= 1'b0;
    else if (evt_i || set_sum_i)  sum_q <= 1'b1;
    else if (clr_sum_i)           sum_q <= 1'b0;
  end
  assign sum_o = sum_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic hit, fl_q;
    assign hit = evt_i && (ch_i == CH_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  fl_q <= 1'b0;
      else if (srst_i)              fl_q <= 1'b0;
      else if (hit || set_ch_i[c])  fl_q <= 1'b1;  // event beats clear
      else if (clr_ch_i[c])         fl_q <= 1'b0;
    end
    assign ch_o[c] = fl_q;

    a_r8_ch_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_ch_i[c] && !hit && !set_ch_i[c]) |=> !ch_o[c]);
  end

  // R5 on the receive bank, R7 on the transmit bank
  a_r5_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !srst_i) |=> sum_o);
  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sum_i && !evt_i && !set_sum_i && !srst_i) |=> !sum_o);
  a_r9_set_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_sum_i && !srst_i) |=> sum_o);
endmodule

// File: rtl/aud_csr_irq.sv
module aud_csr_irq import aud_csr_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          set_wr_i,
  input  logic          clr_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (srst_i)    mask_q <= '0;
    else if (clr_wr_i)  mask_q <= mask_q & ~wdata_i;
    else if (set_wr_i)  mask_q <= mask_q | (wdata_i & IRQ_LEGAL);
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_i & mask_q);

  a_r10_mask_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~IRQ_LEGAL) == '0);
  a_r10_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((mask_o & $past(wdata_i)) == '0));
  a_r10_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr_i && !clr_wr_i && !srst_i) |=> ((mask_o & $past(wdata_i) & IRQ_LEGAL) == ($past(wdata_i) & IRQ_LEGAL)));
  a_r11_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_o != '0));
endmodule

// File: rtl/aud_ser_csr.sv
module aud_ser_csr import aud_csr_pkg::*; #(
  parameter int unsigned   AW      = 4,
  parameter int unsigned   CH_N    = 8,
  parameter logic [31:0]   VERSION = 32'h0001_0300,
  localparam int unsigned  CH_W    = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            rx_word_i,
  input  logic [CH_W-1:0] rx_ch_i,
  input  logic [DW-1:0]   rx_data_i,
  input  logic            tx_take_i,
  input  logic [CH_W-1:0] tx_ch_i,
  output logic [DW-1:0]   tx_data_o,
  output logic            rx_en_o,
  output logic            tx_en_o,
  output logic            clk_en_o,
  output logic [DW-1:0]   mode_o,
  output logic            irq_o
);
  // ---------------- decode
  logic wr_ok, rd_ok;
  logic wr_ctrl, wr_mode, wr_sclr, wr_sset, wr_ien, wr_idis, wr_txh, rd_rxh;
  logic srst;

  assign wr_ok   = req_i && we_i;
  assign rd_ok   = req_i && !we_i;
  assign wr_ctrl = wr_ok && (addr_i == AW'(R_CTRL));
  assign wr_mode = wr_ok && (addr_i == AW'(R_MODE));
  assign wr_sclr = wr_ok && (addr_i == AW'(R_SCLR));
  assign wr_sset = wr_ok && (addr_i == AW'(R_SSET));
  assign wr_ien  = wr_ok && (addr_i == AW'(R_IEN));
  assign wr_idis = wr_ok && (addr_i == AW'(R_IDIS));
  assign wr_txh  = wr_ok && (addr_i == AW'(R_TXH));
  assign rd_rxh  = rd_ok && (addr_i == AW'(R_RXH));
  assign srst    = wr_ctrl && wdata_i[CT_SWRST];

  // ---------------- enables
  logic [N_EN-1:0] en;

  aud_csr_enables #(.N_PAIR(N_EN)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .wr_i   (wr_ctrl),
    .on_i   ({wdata_i[4], wdata_i[2], wdata_i[0]}),
    .off_i  ({wdata_i[5], wdata_i[3], wdata_i[1]}),
    .en_o   (en)
  );

  assign rx_en_o  = en[0];
  assign clk_en_o = en[1];
  assign tx_en_o  = en[2];

  // ---------------- mode
  logic [DW-1:0] mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (srst)     mode_q <= '0;
    else if (wr_mode)  mode_q <= wdata_i;
  end
  assign mode_o = mode_q;

  // ---------------- receive side
  logic          rx_evt, rx_rdy_q, ovr_evt;
  logic [DW-1:0] rx_hold_q;

  assign rx_evt  = rx_word_i && en[0];
  assign ovr_evt = rx_evt && rx_rdy_q && !rd_rxh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rdy_q  <= 1'b0;
      rx_hold_q <= '0;
    end else if (srst) begin
      rx_rdy_q  <= 1'b0;
      rx_hold_q <= '0;
    end else begin
      if (rx_evt)       rx_rdy_q <= 1'b1;
      else if (rd_rxh)  rx_rdy_q <= 1'b0;
      if (rx_evt)       rx_hold_q <= rx_data_i;
    end
  end

  // ---------------- transmit side
  logic          tx_evt, tx_empty_q, und_evt;
  logic [DW-1:0] tx_hold_q;

  assign tx_evt  = tx_take_i && en[2];
  assign und_evt = tx_evt && tx_empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_empty_q <= 1'b1;
      tx_hold_q  <= '0;
    end else if (srst) begin
      tx_empty_q <= 1'b1;
      tx_hold_q  <= '0;
    end else begin
      if (wr_txh)       tx_empty_q <= 1'b0;
      else if (tx_evt)  tx_empty_q <= 1'b1;
      if (wr_txh)       tx_hold_q  <= wdata_i;
    end
  end
  assign tx_data_o = tx_hold_q;

  // ---------------- sticky error banks: 0 = rx overrun, 1 = tx underrun
  logic [1:0]      err_sum;
  logic [CH_N-1:0] err_ch [2];
  logic [1:0]      err_evt;
  logic [CH_W-1:0] err_idx [2];

  assign err_evt    = {und_evt, ovr_evt};
  assign err_idx[0] = rx_ch_i;
  assign err_idx[1] = tx_ch_i;

  for (genvar j = 0; j < 2; j++) begin : g_err
    localparam int unsigned SB = (j == 0) ? ST_RX_OVR : ST_TX_UND;
    localparam int unsigned CB = (j == 0) ? ST_RX_CH  : ST_TX_CH;

    aud_csr_sticky #(.CH_N(CH_N), .CH_W(CH_W)) u_stk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .srst_i    (srst),
      .evt_i     (err_evt[j]),
      .ch_i      (err_idx[j]),
      .clr_sum_i (wr_sclr && wdata_i[SB]),
      .clr_ch_i  ({CH_N{wr_sclr}} & wdata_i[CB +: CH_N]),
      .set_sum_i (wr_sset && wdata_i[SB]),
      .set_ch_i  ({CH_N{wr_sset}} & wdata_i[CB +: CH_N]),
      .sum_o     (err_sum[j]),
      .ch_o      (err_ch[j])
    );
  end

  // ---------------- status word
  logic [DW-1:0] st;
  always_comb begin
    st                   = '0;
    st[ST_RX_EN]         = en[0];
    st[ST_RX_RDY]        = rx_rdy_q;
    st[ST_RX_OVR]        = err_sum[0];
    st[ST_TX_EN]         = en[2];
    st[ST_TX_RDY]        = en[2] && tx_empty_q;
    st[ST_TX_UND]        = err_sum[1];
    st[ST_RX_CH +: CH_N] = err_ch[0];
    st[ST_TX_CH +: CH_N] = err_ch[1];
  end

  // ---------------- interrupt
  logic [DW-1:0] mask;

  aud_csr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst),
    .set_wr_i (wr_ien),
    .clr_wr_i (wr_idis),
    .wdata_i  (wdata_i),
    .status_i (st),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  // ---------------- read mux
  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      case (addr_i)
        AW'(R_MODE): rdata_o = mode_q;
        AW'(R_STAT): rdata_o = st;
        AW'(R_IMSK): rdata_o = mask;
        AW'(R_RXH):  rdata_o = rx_hold_q;
        AW'(R_VER):  rdata_o = VERSION;
        default:     rdata_o = '0;
      endcase
    end
  end

  // ---------------- assertions
  a_r4_read_clears_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxh && !rx_evt) |=> !rx_rdy_q);
  a_r4_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_o && !srst) |=> $stable(rx_hold_q));
  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txh && !srst) |=> !tx_empty_q);
  a_r12_swrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (mode_o == '0 && !rx_en_o && !tx_en_o && !clk_en_o && !irq_o && tx_empty_q));
endmodule

// File: tb/aud_ser_csr_test.sv
module aud_ser_csr_test;
  localparam logic [31:0] VER = 32'h0001_0300;
  localparam logic [31:0] STK = 32'h0FF0_FF44;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_word = 1'b0, tx_take = 1'b0;
  logic [2:0]  rx_ch = '0, tx_ch = '0;
  logic [31:0] rx_data = '0, tx_data, mode;
  logic        rx_en, tx_en, clk_en, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  aud_ser_csr #(.AW(4), .CH_N(8), .VERSION(VER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_word_i(rx_word), .rx_ch_i(rx_ch),
    .rx_data_i(rx_data), .tx_take_i(tx_take), .tx_ch_i(tx_ch),
    .tx_data_o(tx_data), .rx_en_o(rx_en), .tx_en_o(tx_en), .clk_en_o(clk_en),
    .mode_o(mode), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic rx_pulse(input logic [2:0] c, input logic [31:0] d);
    @(negedge clk); rx_word = 1'b1; rx_ch = c; rx_data = d;
    @(negedge clk); rx_word = 1'b0;
  endtask

  task automatic tx_pulse(input logic [2:0] c);
    @(negedge clk); tx_take = 1'b1; tx_ch = c;
    @(negedge clk); tx_take = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(4'd2, rv);  chk("R13 reset status", rv, 32'h0);
    rd(4'd7, rv);  chk("R10 reset mask", rv, 32'h0);
    rd(4'd10, rv); chk("R1 version", rv, VER);
    chk("R12 reset outputs", {28'h0, irq, rx_en, tx_en, clk_en}, 32'h0);

    // mode
    wr(4'd1, 32'hA5A5_5A5A); rd(4'd1, rv);
    chk("R3 mode readback", rv, 32'hA5A5_5A5A);
    wr(4'd1, 32'hFFFF_FFFF); chk("R3 mode_o", mode, 32'hFFFF_FFFF);
    rd(4'd0, rv); chk("R1 control reads zero", rv, 32'h0);

    // strobe sweep (R2, R13)
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 64; v++) begin
        logic [2:0] e;
        wr(4'd0, (p != 0) ? 32'h15 : 32'h2A);
        wr(4'd0, 32'(v));
        for (int k = 0; k < 3; k++)
          e[k] = v[2*k+1] ? 1'b0 : (v[2*k] ? 1'b1 : (p != 0));
        chk("R2 enables", {29'h0, tx_en, clk_en, rx_en}, {29'h0, e});
        rd(4'd2, rv);
        chk("R13 status enables", rv, {26'h0, e[2], e[2], 3'b000, e[0]});
      end
    end

    // receiver disabled: ignored (R4)
    rx_pulse(3'd0, 32'hDEAD_BEEF);
    rd(4'd2, rv); chk("R4 disabled rx status", rv, 32'h0);
    rd(4'd8, rv); chk("R4 disabled rx holding", rv, 32'h0);

    // receive path and overrun per channel (R4, R5, R8)
    wr(4'd0, 32'h29);
    rx_pulse(3'd2, 32'h1357_9BDF);
    rd(4'd2, rv); chk("R4 rx ready", rv, 32'h3);
    rd(4'd8, rv); chk("R4 rx holding", rv, 32'h1357_9BDF);
    rd(4'd2, rv); chk("R4 read clears ready", rv, 32'h1);
    for (int c = 0; c < 8; c++) begin
      rx_pulse(3'(c), 32'(c * 32'h111 + 1));
      rx_pulse(3'(c), 32'(c * 32'h111 + 2));
      rd(4'd2, rv); chk("R5 overrun channel", rv, 32'h7 | (32'h1 << (8 + c)));
      rd(4'd8, rv); chk("R4 latest word", rv, 32'(c * 32'h111 + 2));
      wr(4'd3, 32'h4 | (32'h1 << (8 + c)));
      rd(4'd2, rv); chk("R8 overrun cleared", rv, 32'h1);
    end

    // underrun per channel (R7, R8)
    wr(4'd0, 32'h12);
    rd(4'd2, rv); chk("R6 tx empty after reset", rv, 32'h30);
    for (int c = 0; c < 8; c++) begin
      tx_pulse(3'(c));
      rd(4'd2, rv); chk("R7 underrun channel", rv, 32'h70 | (32'h1 << (20 + c)));
      wr(4'd3, 32'h40 | (32'h1 << (20 + c)));
      rd(4'd2, rv); chk("R8 underrun cleared", rv, 32'h30);
    end

    // clear colliding with event: event wins (R8)
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'd3; wdata = 32'h40 | (32'h1 << 23);
    tx_take = 1'b1; tx_ch = 3'd3;
    @(posedge clk); #1 req = 1'b0; we = 1'b0; tx_take = 1'b0;
    rd(4'd2, rv); chk("R8 event beats clear", rv, 32'h70 | (32'h1 << 23));
    wr(4'd3, 32'hFFFF_FFFF);

    // transmit holding (R6)
    wr(4'd9, 32'hCAFE_F00D);
    chk("R6 tx_data_o", tx_data, 32'hCAFE_F00D);
    rd(4'd2, rv); chk("R6 full clears ready", rv, 32'h10);
    rd(4'd9, rv); chk("R1 tx holding reads zero", rv, 32'h0);
    tx_pulse(3'd0);
    rd(4'd2, rv); chk("R6 take empties, no underrun", rv, 32'h30);

    // status set port (R9) and clear-all (R8)
    wr(4'd0, 32'h22);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd2, rv); chk("R9 set only sticky bits", rv, STK);
    rd(4'd4, rv); chk("R1 set port reads zero", rv, 32'h0);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd2, rv); chk("R8 clear all", rv, 32'h0);

    // mask sweep (R10, R11)
    wr(4'd4, 32'h4);
    for (int m = 0; m < 16; m++) begin
      logic [31:0] e;
      e = (32'(m & 1) << 1) | (32'((m >> 1) & 1) << 2) |
          (32'((m >> 2) & 1) << 5) | (32'((m >> 3) & 1) << 6);
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd5, e | 32'hFFFF_FF99);
      rd(4'd7, rv); chk("R10 mask legal bits", rv, e);
      chk("R11 irq from overrun", {31'h0, irq}, 32'((m >> 1) & 1));
    end
    wr(4'd6, 32'hFFFF_FFFF);
    chk("R11 irq off when unmasked", {31'h0, irq}, 32'h0);
    wr(4'd5, 32'h66); wr(4'd6, 32'h04);
    rd(4'd7, rv); chk("R10 partial clear", rv, 32'h62);
    chk("R11 masked-out bit", {31'h0, irq}, 32'h0);
    wr(4'd3, 32'h4);

    // level follows rx ready (R11)
    wr(4'd0, 32'h1);
    rx_pulse(3'd1, 32'h0000_00AA);
    chk("R11 irq on rx ready", {31'h0, irq}, 32'h1);
    rd(4'd8, rv);
    chk("R11 irq drops on read", {31'h0, irq}, 32'h0);

    // software reset (R12)
    wr(4'd1, 32'h1234_5678); wr(4'd0, 32'h15);
    wr(4'd4, STK); wr(4'd9, 32'h0000_ABCD);
    chk("R11 irq before reset", {31'h0, irq}, 32'h1);
    wr(4'd0, 32'h95);
    chk("R12 outputs cleared", {28'h0, irq, rx_en, tx_en, clk_en}, 32'h0);
    chk("R12 mode cleared", mode, 32'h0);
    chk("R12 tx holding cleared", tx_data, 32'h0);
    rd(4'd2, rv); chk("R12 status cleared", rv, 32'h0);
    rd(4'd7, rv); chk("R12 mask cleared", rv, 32'h0);
    rd(4'd8, rv); chk("R12 rx holding cleared", rv, 32'h0);
    wr(4'd0, 32'h10);
    rd(4'd2, rv); chk("R12 tx empty restored", rv, 32'h30);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule